// File: doc/BRIEF.md
# Matrix LRU Replacement Tracker

This block keeps the recency order of the ways in one set of a set-associative cache. It holds a square bit matrix with one row and one column per way. When a way is used, a single-cycle update makes that way the most recent, and the replacement choice follows from the row values. A cache that has many sets instantiates one tracker per set. Tag lookup and victim data handling stay outside the block.

Each way's row is read as a binary number with column 0 in the most significant position. The way whose row has the smallest value is the replacement victim. If several rows share that value, which happens after reset or while some ways have never been used, the lowest way index wins. The number of set bits in a row gives that way's recency rank, from 0 (least recent) to A−1 (most recent). The associativity A is a parameter, and A = 1 is accepted as a degenerate case.

Top module: `lru_matrix_unit`

## Requirements
- R1: While reset is low at a clock edge, every matrix bit becomes 0. After reset, `victim_way_o` is 0 and every rank field is 0.
- R2: A use of way k (`use_valid_i` high, `use_way_i` = k < WAYS) at a clock edge makes the rank of way k equal WAYS−1 from the next cycle on.
- R3: `victim_way_o` is the way whose row has the lowest value when read with column 0 as the MSB. Ties go to the lowest way index, so after reset and a single use of way 0 the victim is way 1. The victim's rank is always 0.
- R4: `rank_o[k*IDX_W +: IDX_W]` holds the number of ones in row k. For a way that has been used, this is WAYS−1 minus its position in the most-recent-first use order. For a way never used since reset, it is 0.
- R5: A cycle with `use_valid_i` low leaves the victim and all ranks unchanged.
- R6: With WAYS = 4, using ways 0,1,2,3,2,1,0,3,2,3 in order leaves way 1 as the victim, with ranks way0=1, way1=0, way2=2, way3=3.
- R7: Using the way that is already most recent leaves all ranks and the victim unchanged.
- R8: With WAYS = 1, the victim is always way 0 and its rank is always 0, whatever the use inputs are. A `use_way_i` value of WAYS or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_valid_i | input | 1 | Use strobe for the way given on `use_way_i` |
| use_way_i | input | IDX_W | Index of the way being used |
| victim_way_o | output | IDX_W | Least recently used way (combinational) |
| rank_o | output | WAYS*IDX_W | Rank of each way, way k in bits [k*IDX_W +: IDX_W] |

## Verification
The four-way tracker is driven through these input patterns:
- The fixed ten-use sequence. Its end result tells the row-value victim rule apart from rules that look only at the last use or at a use count.
- A single use right after reset. This shows whether ties among the all-zero rows go to the lowest index.
- A long pseudo-random use stream. It includes repeated uses of the most recent way and idle gaps, and checks the full rank vector against a recency queue on every cycle.
- A reset in the middle of the stream, followed by the fixed sequence again.

A one-way instance is also driven with in-range and out-of-range indices. This confirms that it never reports anything but way 0.

// File: rtl/lru_matrix_pkg.sv
// Package: shared helpers for the matrix LRU tracker.
// Assumes: ways >= 1.
package lru_matrix_pkg;
    // Width of a way index; at least one bit even for a single way
    function automatic int unsigned idx_width(input int unsigned ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction
endpackage

// File: rtl/lru_row_store.sv
// Module: holds the WAYS x WAYS recency matrix of one set and applies the
// row-set / column-clear update on a use strobe in a single cycle.
// Assumes: the caller guards nothing; out-of-range way indices are dropped here.
// Layout: bit (r*WAYS + c) is row r, column c.
module lru_row_store #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    use_valid_i,
    input  logic [IDX_W-1:0]        use_way_i,
    output logic [WAYS*WAYS-1:0]    rows_o
);
    logic [WAYS*WAYS-1:0] mat_q;
    logic [WAYS*WAYS-1:0] mat_nxt;
    logic                 way_ok;

    // Accept only indices that name an existing way
    always_comb way_ok = (int'(use_way_i) < int'(WAYS));

    // Build the next matrix: used row to ones, then used column to zeros
    always_comb begin
        mat_nxt = mat_q;
        for (int r = 0; r < int'(WAYS); r++) begin
            for (int c = 0; c < int'(WAYS); c++) begin
                if (r == int'(use_way_i))
                    mat_nxt[r*WAYS + c] = (c != int'(use_way_i));
                else if (c == int'(use_way_i))
                    mat_nxt[r*WAYS + c] = 1'b0;
            end
        end
    end

    // Matrix register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            mat_q <= '0;
        else if (use_valid_i && way_ok)
            mat_q <= mat_nxt;
    end

    assign rows_o = mat_q;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !use_valid_i |=> $stable(mat_q));
endmodule

// File: rtl/lru_min_pick.sv
// Module: selects the way whose row, read with column 0 as MSB, is smallest.
// Assumes: a strict less-than scan, so ties resolve to the lowest index.
module lru_min_pick #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [WAYS*WAYS-1:0] rows_i,
    output logic [IDX_W-1:0]     victim_o
);
    logic [WAYS-1:0] key [WAYS];
    int unsigned     best;

    // Reverse each row so that column 0 lands in the MSB of its key
    always_comb begin
        for (int k = 0; k < int'(WAYS); k++)
            for (int c = 0; c < int'(WAYS); c++)
                key[k][WAYS-1-c] = rows_i[k*WAYS + c];
    end

    // Linear minimum scan, lower index kept on equal keys
    always_comb begin
        best = 0;
        for (int unsigned k = 1; k < WAYS; k++)
            if (key[k] < key[best]) best = k;
        victim_o = IDX_W'(best);
    end
endmodule

// File: rtl/lru_rank_count.sv
// Module: reports each way's recency rank as the popcount of its row.
// Assumes: a row never holds more than WAYS-1 ones (diagonal stays clear).
module lru_rank_count #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [WAYS*WAYS-1:0]  rows_i,
    output logic [WAYS*IDX_W-1:0] rank_o
);
    for (genvar k = 0; k < int'(WAYS); k++) begin : g_rank
        // Count the ones of row k
        always_comb rank_o[k*IDX_W +: IDX_W] = IDX_W'($countones(rows_i[k*WAYS +: WAYS]));
    end
endmodule

// File: rtl/lru_matrix_unit.sv
// Module: top of the per-set matrix LRU tracker. Ties the matrix store to the
// victim selector and the rank counter.
// Assumes: one instance per cache set; use indices >= WAYS are ignored.
module lru_matrix_unit #(
    parameter int unsigned WAYS  = 4,
    localparam int unsigned IDX_W = lru_matrix_pkg::idx_width(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    use_valid_i,
    input  logic [IDX_W-1:0]        use_way_i,
    output logic [IDX_W-1:0]        victim_way_o,
    output logic [WAYS*IDX_W-1:0]   rank_o
);
    logic [WAYS*WAYS-1:0] rows;

    lru_row_store #(.WAYS(WAYS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .use_valid_i(use_valid_i),
        .use_way_i(use_way_i), .rows_o(rows));

    lru_min_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_pick (
        .rows_i(rows), .victim_o(victim_way_o));

    lru_rank_count #(.WAYS(WAYS), .IDX_W(IDX_W)) u_rank (
        .rows_i(rows), .rank_o(rank_o));

    // Assertion support: remember the previous accepted use
    logic [IDX_W-1:0] chk_way_q;
    logic             chk_use_q;
    logic             use_ok;
    always_comb use_ok = use_valid_i && (int'(use_way_i) < int'(WAYS));
    // Track the last accepted use for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_use_q <= 1'b0;
            chk_way_q <= '0;
        end else begin
            chk_use_q <= use_ok;
            chk_way_q <= use_way_i;
        end
    end

    // R2
    used_is_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_use_q |-> rank_o[chk_way_q*IDX_W +: IDX_W] == IDX_W'(WAYS-1));

    // R3
    victim_rank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rank_o[victim_way_o*IDX_W +: IDX_W] == '0);

    // R7
    repeat_use_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ok && chk_use_q && use_way_i == chk_way_q) |=> $stable(rank_o));

    if (WAYS > 1) begin : g_multi
        // R3
        used_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chk_use_q |-> victim_way_o != chk_way_q);
    end else begin : g_single
        // R8
        single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
            victim_way_o == '0 && rank_o == '0);
    end
endmodule

// File: tb/test_lru_matrix_unit.sv
`timescale 1ns/1ps
module test_lru_matrix_unit;
    localparam int W = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic use_valid = 1'b0;
    logic [IW-1:0] use_way = '0;
    logic [IW-1:0] victim;
    logic [W*IW-1:0] rank;

    logic use1_valid = 1'b0;
    logic use1_way = 1'b0;
    logic victim1;
    logic rank1;

    int checks = 0;
    int fails = 0;
    int order[$];      // most recent first
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lru_matrix_unit #(.WAYS(W)) i_lru_matrix_unit (
        .clk(clk), .rst_n(rst_n), .use_valid_i(use_valid), .use_way_i(use_way),
        .victim_way_o(victim), .rank_o(rank));

    lru_matrix_unit #(.WAYS(1)) i_lru_matrix_unit_one (
        .clk(clk), .rst_n(rst_n), .use_valid_i(use1_valid), .use_way_i(use1_way),
        .victim_way_o(victim1), .rank_o(rank1));

    // Reference: expected rank of a way from the recency queue
    function automatic int exp_rank(int w);
        foreach (order[i]) if (order[i] == w) return W - 1 - i;
        return 0;
    endfunction

    // Reference: expected victim, lowest never-used way, else the oldest
    function automatic int exp_victim();
        for (int w = 0; w < W; w++) begin
            bit seen = 1'b0;
            foreach (order[i]) if (order[i] == w) seen = 1'b1;
            if (!seen) return w;
        end
        return order[order.size()-1];
    endfunction

    function automatic void model_use(int w);
        for (int i = order.size() - 1; i >= 0; i--) if (order[i] == w) order.delete(i);
        order.push_front(w);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output of the four-way unit with the model
    task automatic compare_all(string tag);
        check({tag, " victim"}, int'(victim), exp_victim());
        for (int w = 0; w < W; w++)
            check($sformatf("%s rank way%0d", tag, w), int'(rank[w*IW +: IW]), exp_rank(w));
    endtask

    // One cycle: drive at negedge, model at posedge, sample at next negedge
    task automatic step(bit v, int w, string tag);
        @(negedge clk);
        use_valid = v;
        use_way = IW'(w);
        @(posedge clk);
        if (v) model_use(w);
        @(negedge clk);
        use_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        order.delete();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_fixed_sequence();
        int seq[10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
        foreach (seq[i]) step(1'b1, seq[i], "R2 R4 sequence");
        check("R6 victim", int'(victim), 1);
        check("R6 rank way0", int'(rank[0 +: IW]), 1);
        check("R6 rank way1", int'(rank[IW +: IW]), 0);
        check("R6 rank way2", int'(rank[2*IW +: IW]), 2);
        check("R6 rank way3", int'(rank[3*IW +: IW]), 3);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        compare_all("R1 reset");
        check("R1 victim", int'(victim), 0);

        step(1'b1, 0, "R3 single use");
        check("R3 tie to lowest", int'(victim), 1);
        do_reset();

        run_fixed_sequence();

        // R5: idle cycles leave everything alone
        for (int i = 0; i < 4; i++) step(1'b0, 0, "R5 idle");

        // R7: reuse of the most recent way
        step(1'b1, 3, "R7 first");
        step(1'b1, 3, "R7 repeat");
        step(1'b1, 3, "R7 repeat again");

        // R4: long pseudo-random stream with gaps and repeats
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, int'($urandom % W), "R4 random");

        // R1: reset mid-run, then the fixed sequence again
        do_reset();
        @(negedge clk);
        compare_all("R1 mid reset");
        run_fixed_sequence();

        // R8: one-way instance, in-range and out-of-range indices
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            use1_valid = i[0];
            use1_way = i[1];
            @(negedge clk);
            check("R8 one-way victim", int'(victim1), 0);
            check("R8 one-way rank", int'(rank1), 0);
        end
        use1_valid = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule